// File: doc/BRIEF.md
# Shadowed Real-Time Clock with Alarms

This block is a real-time clock peripheral. It counts time from a 32.768 kHz tick enable and is accessed over a small synchronous register bus. A fractional accumulator derives a milliseconds count from the tick. The milliseconds count runs from 0 to 999 and carries into a 32-bit seconds counter. Software does not see these counters directly. Every eighth tick, the block copies both values into a bus-side pair of registers and raises a busy flag for the tick period that follows.

Reading the milliseconds register latches the bus-side seconds into a separate shadow register. Software can then read a seconds and milliseconds pair that belong to the same instant. Register writes are taken only while the busy flag is low. A write that arrives during the busy window is discarded.

Two seconds-match alarms and one milliseconds-match alarm feed an interrupt status register whose bits are cleared by writing 1. A mask register selects which status bits drive the level interrupt output.

Top module: `rtc_shadow_top`

## Requirements
- R1: After synchronous reset, every register reads 0, the busy bit reads 0 and `irq` is 0.
- R2: Each tick adds 1000 to a fractional accumulator. When the sum reaches `TICK_HZ`, `TICK_HZ` is subtracted and milliseconds advances. Milliseconds wraps from 999 to 0 and increments seconds on that wrap. After n ticks from reset with no seconds load, milliseconds is floor(n·1000/TICK_HZ) mod 1000.
- R3: On ticks number 8, 16, 24 and so on after reset, the bus-side seconds (offset 0x008) and milliseconds (offset 0x010) take the counter values as they stood just before that tick. Between those ticks they hold.
- R4: Bit 0 of offset 0x004 reads 1 from the copy tick until the next tick, and reads 0 otherwise.
- R5: A read of offset 0x010 loads the shadow register (offset 0x00C) with the bus-side seconds of that same cycle.
- R6: Reads are served at any time. A write while busy is 1 changes no register.
- R7: A write to offset 0x008 while busy is 0 loads the seconds counter. The bus-side seconds show the new value after the next copy.
- R8: The seconds alarms at 0x014 and 0x018 set status bit 0 and bit 1 respectively. A bit is set the cycle after the seconds counter changes, by counting or by load, to a value equal to its alarm register. An alarm register holding 0 never matches.
- R9: The milliseconds alarm at 0x01C (10 bits) sets status bit 2 when milliseconds changes to its nonzero value.
- R10: Writing 1 to a bit of the status register (0x02C) clears it. Writing 0 leaves it unchanged.
- R11: The mask register (0x028, 5 bits, all stored) gates only the output. `irq` is 1 exactly when some status bit and its mask bit are both 1, with one cycle of delay. Status bits 3 and 4 are never set.
- R12: `bus_rdata` holds the addressed value in the cycle after `bus_rd`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle pulse per 32.768 kHz period |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
A sweep of tick bursts of every length from 1 to 20 checks the copy and busy timing against every phase of the eight-tick cycle. A design that copies on the wrong tick, or copies the already-advanced counters, shows bus-side time that is off by one millisecond. Writes are aimed at the busy window to catch a design that still accepts them there. A shadow register that misses the milliseconds read would return stale seconds.

The alarm checks use both a counted rollover and a direct load. They check that a zero alarm stays silent and that a masked bit still sets status. A design that gated status with the mask, or matched zero, would show the wrong status value. Status writes carrying 0 bits confirm that clearing is bit-selective.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int NUM_IRQ    = 5;
  localparam int NUM_SEC_AL = 2;

  localparam logic [ADDR_W-1:0] OFS_BUSY   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_SEC    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SHADOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MS     = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_SAL0   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MSAL   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h2C;

  // status/mask bit positions; bits 3 and 4 are reserved countdown slots
  localparam int BIT_SAL0 = 0;
  localparam int BIT_MSAL = 2;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int TICK_HZ    = 32768,
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  localparam int MS_W      = $clog2(MS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             load_en,
  input  logic [SEC_W-1:0] load_val,
  output logic [SEC_W-1:0] sec_o,
  output logic [MS_W-1:0]  ms_o,
  output logic             sec_chg_o,
  output logic             ms_chg_o
);
  localparam int ACC_W = $clog2(TICK_HZ + MS_PER_SEC);
  localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

  logic [ACC_W-1:0] acc_q, acc_n, acc_sum;
  logic [MS_W-1:0]  ms_q, ms_n;
  logic [SEC_W-1:0] sec_q, sec_n;
  logic             sec_chg_q, ms_chg_q;

  assign acc_sum = acc_q + ACC_W'(MS_PER_SEC);

  always_comb begin
    acc_n = acc_q;
    ms_n  = ms_q;
    sec_n = sec_q;
    if (tick_en) begin
      if (acc_sum >= ACC_W'(TICK_HZ)) begin
        acc_n = acc_sum - ACC_W'(TICK_HZ);
        if (ms_q == MS_LAST) begin
          ms_n  = '0;
          sec_n = sec_q + SEC_W'(1);
        end else begin
          ms_n = ms_q + MS_W'(1);
        end
      end else begin
        acc_n = acc_sum;
      end
    end
    if (load_en) sec_n = load_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      ms_q      <= '0;
      sec_q     <= '0;
      sec_chg_q <= 1'b0;
      ms_chg_q  <= 1'b0;
    end else begin
      acc_q     <= acc_n;
      ms_q      <= ms_n;
      sec_q     <= sec_n;
      sec_chg_q <= (sec_n != sec_q);
      ms_chg_q  <= (ms_n != ms_q);
    end
  end

  assign sec_o     = sec_q;
  assign ms_o      = ms_q;
  assign sec_chg_o = sec_chg_q;
  assign ms_chg_o  = ms_chg_q;

  assert_ms_range_R2: assert property (@(posedge clk) disable iff (rst)
    ms_q <= MS_LAST);
  assert_sec_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !load_en) |=> $stable(sec_q));
  assert_ms_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(ms_q));
endmodule

// File: rtl/rtc_busside.sv
module rtc_busside #(
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10,
  parameter int PHASES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic [SEC_W-1:0] core_sec,
  input  logic [MS_W-1:0]  core_ms,
  output logic [SEC_W-1:0] bus_sec_o,
  output logic [MS_W-1:0]  bus_ms_o,
  output logic             busy_o
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [PH_W-1:0]  phase_q;
  logic [SEC_W-1:0] bsec_q;
  logic [MS_W-1:0]  bms_q;
  logic             busy_q;
  logic             copy_now;

  assign copy_now = tick_en && (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      bsec_q  <= '0;
      bms_q   <= '0;
      busy_q  <= 1'b0;
    end else if (tick_en) begin
      phase_q <= copy_now ? '0 : phase_q + PH_W'(1);
      busy_q  <= copy_now;
      if (copy_now) begin
        bsec_q <= core_sec;
        bms_q  <= core_ms;
      end
    end
  end

  assign bus_sec_o = bsec_q;
  assign bus_ms_o  = bms_q;
  assign busy_o    = busy_q;

  assert_busy_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(tick_en));
  assert_copy_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> ($stable(bsec_q) && $stable(bms_q) && $stable(busy_q)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int SEC_W  = 32,
  parameter int MS_W   = 10,
  parameter int NUM_AL = 2
) (
  input  logic [SEC_W-1:0]             sec,
  input  logic                         sec_chg,
  input  logic [MS_W-1:0]              ms,
  input  logic                         ms_chg,
  input  logic [NUM_AL-1:0][SEC_W-1:0] sec_alarm,
  input  logic [MS_W-1:0]              ms_alarm,
  output logic [NUM_AL-1:0]            sec_hit,
  output logic                         ms_hit
);
  for (genvar i = 0; i < NUM_AL; i++) begin : g_sec_cmp
    assign sec_hit[i] = sec_chg && (sec_alarm[i] != '0) && (sec == sec_alarm[i]);
  end

  assign ms_hit = ms_chg && (ms_alarm != '0) && (ms == ms_alarm);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int NB = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NB-1:0] set_i,
  input  logic [NB-1:0] clr_i,
  input  logic          mask_we,
  input  logic [NB-1:0] mask_wdata,
  output logic [NB-1:0] status_o,
  output logic [NB-1:0] mask_o,
  output logic          irq_o
);
  logic [NB-1:0] status_q, mask_q;
  logic          irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;
      if (mask_we) mask_q <= mask_wdata;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  assert_w1c_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_i[0] && !set_i[0]) |=> !status_q[0]);
  assert_set_unmasked_R11: assert property (@(posedge clk) disable iff (rst)
    set_i[0] |=> status_q[0]);
  assert_mask_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_q);
endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
  import rtc_pkg::*;
#(
  parameter int TICK_HZ    = 32768,
  parameter int MS_PER_SEC = 1000,
  parameter int PHASES     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int SEC_W = DATA_W;
  localparam int MS_W  = $clog2(MS_PER_SEC);

  logic [SEC_W-1:0] core_sec, bus_sec, shadow_q;
  logic [MS_W-1:0]  core_ms, bus_ms, msal_q;
  logic             sec_chg, ms_chg, busy, wr_ok;
  logic [NUM_SEC_AL-1:0][SEC_W-1:0] sal_q;
  logic [NUM_SEC_AL-1:0] sec_hit;
  logic             ms_hit;
  logic [NUM_IRQ-1:0] set_vec, clr_vec, status, mask;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign wr_ok = bus_wr && !busy;

  rtc_timebase #(.TICK_HZ(TICK_HZ), .MS_PER_SEC(MS_PER_SEC), .SEC_W(SEC_W)) u_time (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .load_en(wr_ok && (bus_addr == OFS_SEC)), .load_val(bus_wdata),
    .sec_o(core_sec), .ms_o(core_ms), .sec_chg_o(sec_chg), .ms_chg_o(ms_chg)
  );

  rtc_busside #(.SEC_W(SEC_W), .MS_W(MS_W), .PHASES(PHASES)) u_bus (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .core_sec(core_sec), .core_ms(core_ms),
    .bus_sec_o(bus_sec), .bus_ms_o(bus_ms), .busy_o(busy)
  );

  rtc_alarm_match #(.SEC_W(SEC_W), .MS_W(MS_W), .NUM_AL(NUM_SEC_AL)) u_match (
    .sec(core_sec), .sec_chg(sec_chg), .ms(core_ms), .ms_chg(ms_chg),
    .sec_alarm(sal_q), .ms_alarm(msal_q), .sec_hit(sec_hit), .ms_hit(ms_hit)
  );

  always_comb begin
    set_vec = '0;
    for (int i = 0; i < NUM_SEC_AL; i++) set_vec[BIT_SAL0 + i] = sec_hit[i];
    set_vec[BIT_MSAL] = ms_hit;
  end

  assign clr_vec = (wr_ok && (bus_addr == OFS_STAT)) ? bus_wdata[NUM_IRQ-1:0] : '0;

  rtc_irq_ctrl #(.NB(NUM_IRQ)) u_irq (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_i(clr_vec),
    .mask_we(wr_ok && (bus_addr == OFS_MASK)), .mask_wdata(bus_wdata[NUM_IRQ-1:0]),
    .status_o(status), .mask_o(mask), .irq_o(irq)
  );

  // alarm compare registers
  for (genvar i = 0; i < NUM_SEC_AL; i++) begin : g_sal
    localparam logic [ADDR_W-1:0] OFS_I = OFS_SAL0 + ADDR_W'(4 * i);
    always_ff @(posedge clk) begin
      if (rst) sal_q[i] <= '0;
      else if (wr_ok && (bus_addr == OFS_I)) sal_q[i] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) msal_q <= '0;
    else if (wr_ok && (bus_addr == OFS_MSAL)) msal_q <= bus_wdata[MS_W-1:0];
  end

  // shadow seconds captured on a milliseconds read
  always_ff @(posedge clk) begin
    if (rst) shadow_q <= '0;
    else if (bus_rd && (bus_addr == OFS_MS)) shadow_q <= bus_sec;
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SEC_AL; i++)
      if (bus_addr == OFS_SAL0 + ADDR_W'(4 * i)) rd_mux = sal_q[i];
    case (bus_addr)
      OFS_BUSY:   rd_mux = DATA_W'(busy);
      OFS_SEC:    rd_mux = bus_sec;
      OFS_SHADOW: rd_mux = shadow_q;
      OFS_MS:     rd_mux = DATA_W'(bus_ms);
      OFS_MSAL:   rd_mux = DATA_W'(msal_q);
      OFS_MASK:   rd_mux = DATA_W'(mask);
      OFS_STAT:   rd_mux = DATA_W'(status);
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  assert_drop_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && busy) |=> ($stable(sal_q) && $stable(msal_q) && $stable(mask)));
  assert_shadow_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFS_MS)) |=> (shadow_q == $past(bus_sec)));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rdata_q));
endmodule

// File: tb/rtc_shadow_top_tb.sv
module rtc_shadow_top_tb;
  localparam int T_HZ = 4000;
  localparam int MSPS = 1000;

  logic        clk = 1'b0, rst = 1'b1, tick_en = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #5 clk = ~clk;

  rtc_shadow_top #(.TICK_HZ(T_HZ), .MS_PER_SEC(MSPS), .PHASES(8)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  int m_acc = 0, m_ms = 0, m_phase = 0;
  logic [31:0] m_sec = 0, m_bsec = 0, m_bms = 0, m_shadow = 0, m_al0 = 0, m_al1 = 0, m_alm = 0;
  logic [4:0]  m_mask = 0, m_stat = 0;
  bit m_busy = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sec_events(input logic [31:0] old);
    if (m_sec != old && m_al0 != 0 && m_sec == m_al0) m_stat[0] = 1'b1;
    if (m_sec != old && m_al1 != 0 && m_sec == m_al1) m_stat[1] = 1'b1;
  endtask

  task automatic model_tick();
    logic [31:0] old_sec = m_sec;
    int old_ms = m_ms;
    bit cp = (m_phase == 7);
    if (cp) begin m_bsec = m_sec; m_bms = m_ms; end
    m_busy  = cp;
    m_phase = (m_phase + 1) % 8;
    m_acc  += MSPS;
    if (m_acc >= T_HZ) begin
      m_acc -= T_HZ;
      m_ms++;
      if (m_ms == MSPS) begin m_ms = 0; m_sec++; end
    end
    sec_events(old_sec);
    if (m_ms != old_ms && m_alm != 0 && m_ms == m_alm) m_stat[2] = 1'b1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      model_tick();
    end
    tick_en = 1'b0;
  endtask

  task automatic idle_ok();
    if (m_busy) ticks(1);
  endtask

  task automatic wait_busy();
    while (!m_busy) ticks(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] old;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    if (!m_busy) begin
      case (a)
        8'h08: begin old = m_sec; m_sec = d; sec_events(old); end
        8'h14: m_al0 = d;
        8'h18: m_al1 = d;
        8'h1C: m_alm = d & 32'h3FF;
        8'h28: m_mask = d[4:0];
        8'h2C: m_stat = m_stat & ~d[4:0];
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
    if (a == 8'h10) m_shadow = m_bsec;
  endtask

  task automatic expect_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic chk_irq(input string req);
    @(negedge clk);
    check(req, {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int tgt;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    foreach (v[i]) ;
    expect_rd("R1 busy", 8'h04, 32'd0);
    expect_rd("R1 sec", 8'h08, 32'd0);
    expect_rd("R1 ms", 8'h10, 32'd0);
    expect_rd("R1 shadow", 8'h0C, 32'd0);
    expect_rd("R1 al0", 8'h14, 32'd0);
    expect_rd("R1 al1", 8'h18, 32'd0);
    expect_rd("R1 msal", 8'h1C, 32'd0);
    expect_rd("R1 mask", 8'h28, 32'd0);
    expect_rd("R1 status", 8'h2C, 32'd0);

    // R2 R3 R4 R5 sweep across every copy phase
    for (int b = 1; b <= 20; b++) begin
      ticks(b);
      expect_rd("R4 busy", 8'h04, {31'b0, m_busy});
      expect_rd("R3 bus sec", 8'h08, m_bsec);
      expect_rd("R2 R3 bus ms", 8'h10, m_bms);
      expect_rd("R5 shadow", 8'h0C, m_shadow);
      expect_rd("R9 status idle", 8'h2C, {27'b0, m_stat});
    end

    // R12 unmapped offsets
    expect_rd("R12 unmapped 00", 8'h00, 32'd0);
    expect_rd("R12 unmapped 20", 8'h20, 32'd0);
    expect_rd("R12 unmapped 24", 8'h24, 32'd0);
    expect_rd("R12 unmapped 30", 8'h30, 32'd0);

    // R6 writes during busy are dropped, reads still served
    wait_busy();
    wr(8'h14, 32'd123);
    wr(8'h28, 32'h1F);
    wr(8'h1C, 32'd9);
    expect_rd("R6 al0 dropped", 8'h14, m_al0);
    expect_rd("R6 mask dropped", 8'h28, {27'b0, m_mask});
    expect_rd("R6 msal dropped", 8'h1C, m_alm);
    expect_rd("R6 busy read", 8'h04, 32'd1);
    ticks(1);
    wr(8'h14, 32'd123);
    expect_rd("R6 al0 accepted", 8'h14, 32'd123);
    wr(8'h14, 32'd0);

    // R7 seconds load
    idle_ok();
    wr(8'h08, 32'd1000);
    expect_rd("R7 before copy", 8'h08, m_bsec);
    wait_busy();
    expect_rd("R7 after copy", 8'h08, 32'd1000);
    expect_rd("R7 ms read", 8'h10, m_bms);
    expect_rd("R5 shadow after load", 8'h0C, 32'd1000);

    // R8 alarm on counted rollover, R11 irq
    idle_ok();
    wr(8'h14, m_sec + 1);
    wr(8'h28, 32'h01);
    ticks(T_HZ);
    expect_rd("R8 al0 status", 8'h2C, {27'b0, m_stat});
    check("R8 al0 bit", {31'b0, m_stat[0]}, 32'd1);
    chk_irq("R11 irq on");

    // R10 write-one-to-clear
    idle_ok();
    wr(8'h2C, 32'h02);
    expect_rd("R10 zero bits keep", 8'h2C, 32'h01);
    wr(8'h2C, 32'h01);
    expect_rd("R10 cleared", 8'h2C, 32'h00);
    chk_irq("R11 irq off");

    // R8 zero alarm never matches, load-triggered match on alarm 1
    wr(8'h08, 32'd0);
    expect_rd("R8 zero no match", 8'h2C, 32'h00);
    wr(8'h18, 32'd77);
    wr(8'h08, 32'd77);
    expect_rd("R8 al1 via load", 8'h2C, 32'h02);
    chk_irq("R11 masked stays low");
    wr(8'h28, 32'h02);
    chk_irq("R11 unmask raises");
    check("R11 irq high", {31'b0, irq}, 32'd1);
    wr(8'h2C, 32'h1F);

    // R9 milliseconds alarm
    idle_ok();
    tgt = (m_ms + 5) % MSPS;
    if (tgt == 0) tgt = 1;
    wr(8'h1C, tgt);
    wr(8'h28, 32'h1F);
    expect_rd("R11 mask all bits", 8'h28, 32'h1F);
    ticks(40);
    expect_rd("R9 ms alarm", 8'h2C, {27'b0, m_stat});
    check("R9 bit2", {31'b0, m_stat[2]}, 32'd1);
    chk_irq("R11 ms irq");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule